// File: doc/BRIEF.md
# Reload and One-Shot Down-Counter Timer

The block is a down counter with a programmable period. A trigger loads the counter from a period register and starts it. The trigger can come from software or from a chosen edge on an asynchronous input pin. After that, every cycle in which the count-enable strobe is high takes one off the count. The step below zero is the underflow, so one period covers the programmed value plus one strobes.

There are two modes:

- **Reload mode:** on each underflow the counter reloads and keeps running. The output pin toggles on each underflow.
- **One-shot mode:** on the underflow the counter reloads and then halts with that value held. The output pin is a pulse that is active while counting.

A polarity bit inverts the pin in both modes.

Two sticky flags record events, one for underflows and one for triggers. Each flag has its own enable into a single interrupt line. Software clears a flag by writing 0 to it. Clock division happens outside the block, which only sees the strobe.

The register port is a single-cycle write and a combinational read, addressed by a 2-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit 0 enable, bit 1 software trigger, bit 2 one-shot, bit 3 invert, bits 5:4 edge select |
| 1 | PERIOD | the period value |
| 2 | STATUS | bit 0 underflow flag, bit 1 trigger flag, bit 4 underflow interrupt enable, bit 5 trigger interrupt enable |
| 3 | COUNT | the current count, read-only |

Top module: `reload_timer`

## Requirements
- R1: While running, each cycle with `cnt_en` high decrements COUNT by one. From a trigger, the underflow happens on strobe number PERIOD+1. This also holds for PERIOD = 0, where every strobe underflows.
- R2: On an underflow COUNT is loaded with PERIOD. In reload mode (CTRL bit 2 = 0) counting continues with the next strobe.
- R3: In one-shot mode (CTRL bit 2 = 1) the counter stops after the first underflow. COUNT then holds the PERIOD value and further strobes leave it unchanged.
- R4: CTRL bits 5:4 select which edges of `trig_in` trigger: 00 none, 01 rising, 10 falling, 11 both.
- R5: `trig_in` is synchronised. An edge on it that arrives between two rising clock edges loads COUNT from PERIOD on the third rising clock edge after the change, and starts counting.
- R6: `tmr_out` depends on mode and polarity. In reload mode it is 0 after a trigger and inverts on every underflow. In one-shot mode it is 1 while counting and 0 otherwise. CTRL bit 3 = 1 inverts either waveform.
- R7: Every underflow sets STATUS bit 0. `irq` is high while that flag and STATUS bit 4 are both 1.
- R8: Every accepted trigger, from software or from the pin, sets STATUS bit 1. `irq` is high while that flag and STATUS bit 5 are both 1.
- R9: A CTRL write with bits 0 and 1 both 1 triggers in that cycle, whatever bits 5:4 hold. A write with bit 1 = 1 and bit 0 = 0 does not trigger. CTRL bit 1 always reads 0.
- R10: Clearing CTRL bit 0 stops the counter. COUNT holds its value, strobes have no effect, and `tmr_out` returns to its idle level.
- R11: CTRL bits 2, 3 and 5:4 change only on a write made while CTRL bit 0 reads 0. This includes the write that sets the enable. While the timer is enabled, writes leave these bits unchanged.
- R12: Writing 0 to a STATUS flag bit clears it, and writing 1 leaves it as it is. If the hardware sets a flag in the same cycle as a clear, the flag ends up set.
- R13: A trigger that arrives while the counter is running reloads COUNT from PERIOD and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both write and read |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` (combinational) |
| cnt_en | input | 1 | Count-enable strobe from an external prescaler |
| trig_in | input | 1 | Asynchronous external trigger |
| tmr_out | output | 1 | Timer waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches the counter on every cycle:

- the single-step decrement;
- the reload value after an underflow or a trigger;
- the stop after a one-shot underflow;
- the stop on disable;
- the frozen count while idle;
- the output inversion on a reload underflow;
- the underflow flag.

Several behaviours can only be shown by the bench scenarios, which sweep small periods over both modes and both polarities:

- the exact synchroniser latency;
- the edge-select decoding;
- the configuration lock;
- the race between a flag being set and being cleared;
- the read-as-zero software trigger bit.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd3;

    localparam int C_EN      = 0;
    localparam int C_SW      = 1;
    localparam int C_OS      = 2;
    localparam int C_INV     = 3;
    localparam int C_EDGE_LO = 4;

    localparam int S_UF  = 0;
    localparam int S_TG  = 1;
    localparam int S_UIE = 4;
    localparam int S_TIE = 5;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e edge_sel;
        logic      invert;
        logic      oneshot;
        logic      enable;
    } ctrl_t;

    typedef struct packed {
        logic tie;
        logic uie;
        logic tg;
        logic uf;
    } stat_t;

    function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic wave_level(ctrl_t c, logic running, logic tgl);
        return (c.oneshot ? running : tgl) ^ c.invert;
    endfunction

endpackage

// File: rtl/rt_trig_sync.sv
module rt_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/rt_regs.sv
module rt_regs
    import rt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic              uflow,
    input  logic              trig,
    output ctrl_t             ctrl,
    output stat_t             stat,
    output logic [W-1:0]      period,
    output logic              en_next,
    output logic              sw_trig,
    output logic              irq,
    output logic [W-1:0]      rdata
);
    ctrl_t        ctrl_q;
    stat_t        stat_q, stat_d;
    logic [W-1:0] period_q;
    logic         wr_ctrl, wr_stat, wr_per;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STATUS);
    assign wr_per  = wr_en && (addr == A_PERIOD);

    assign en_next = wr_ctrl ? wdata[C_EN] : ctrl_q.enable;
    assign sw_trig = wr_ctrl && wdata[C_EN] && wdata[C_SW];

    always_comb begin
        stat_d = stat_q;
        if (wr_stat) begin
            stat_d.uie = wdata[S_UIE];
            stat_d.tie = wdata[S_TIE];
            if (!wdata[S_UF]) stat_d.uf = 1'b0;
            if (!wdata[S_TG]) stat_d.tg = 1'b0;
        end
        if (uflow) stat_d.uf = 1'b1;
        if (trig)  stat_d.tg = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            stat_q   <= '0;
            period_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_per) period_q <= wdata;
            if (wr_ctrl) begin
                ctrl_q.enable <= wdata[C_EN];
                if (!ctrl_q.enable) begin
                    ctrl_q.oneshot  <= wdata[C_OS];
                    ctrl_q.invert   <= wdata[C_INV];
                    ctrl_q.edge_sel <= edge_sel_e'(wdata[C_EDGE_LO+1:C_EDGE_LO]);
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[C_EN]                = ctrl_q.enable;
                rdata[C_OS]                = ctrl_q.oneshot;
                rdata[C_INV]               = ctrl_q.invert;
                rdata[C_EDGE_LO+1:C_EDGE_LO] = ctrl_q.edge_sel;
            end
            A_PERIOD: rdata = period_q;
            A_STATUS: begin
                rdata[S_UF]  = stat_q.uf;
                rdata[S_TG]  = stat_q.tg;
                rdata[S_UIE] = stat_q.uie;
                rdata[S_TIE] = stat_q.tie;
            end
            default: rdata = count;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign stat   = stat_q;
    assign period = period_q;
    assign irq    = (stat_q.uf & stat_q.uie) | (stat_q.tg & stat_q.tie);
endmodule

// File: rtl/rt_core.sv
module rt_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         trig,
    input  logic         en_next,
    input  logic         oneshot,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         running,
    output logic         tgl,
    output logic         uflow
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_q;
    logic         running_q, tgl_q, at_zero;

    assign at_zero = (count_q == '0);
    assign uflow   = running_q && en_next && cnt_en && at_zero && !trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            running_q <= 1'b0;
            tgl_q     <= 1'b0;
        end else if (!en_next) begin
            running_q <= 1'b0;
            tgl_q     <= 1'b0;
        end else if (trig) begin
            count_q   <= period;
            running_q <= 1'b1;
            tgl_q     <= 1'b0;
        end else if (running_q && cnt_en) begin
            if (at_zero) begin
                count_q <= period;
                tgl_q   <= ~tgl_q;
                if (oneshot) running_q <= 1'b0;
            end else begin
                count_q <= count_q - ONE;
            end
        end
    end

    assign count   = count_q;
    assign running = running_q;
    assign tgl     = tgl_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rt_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              cnt_en,
    input  logic              trig_in,
    output logic              tmr_out,
    output logic              irq
);
    ctrl_t        ctrl_w;
    stat_t        stat_w;
    logic [W-1:0] period_w, count_w;
    logic         en_next_w, sw_trig_w, trig_w, uflow_w;
    logic         running_w, tgl_w, rise_w, fall_w;

    rt_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin(trig_in), .rise(rise_w), .fall(fall_w)
    );

    rt_regs #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count(count_w), .uflow(uflow_w), .trig(trig_w),
        .ctrl(ctrl_w), .stat(stat_w), .period(period_w),
        .en_next(en_next_w), .sw_trig(sw_trig_w), .irq(irq), .rdata(rdata)
    );

    assign trig_w = en_next_w && (sw_trig_w || edge_hit(ctrl_w.edge_sel, rise_w, fall_w));

    rt_core #(.W(W)) core_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .trig(trig_w),
        .en_next(en_next_w), .oneshot(ctrl_w.oneshot), .period(period_w),
        .count(count_w), .running(running_w), .tgl(tgl_w), .uflow(uflow_w)
    );

    assign tmr_out = wave_level(ctrl_w, running_w, tgl_w);
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] count,
    input logic [W-1:0] period,
    input logic         running,
    input logic         uflow,
    input logic         trig,
    input logic         en_next,
    input logic         cnt_en,
    input logic         oneshot,
    input logic         uf_flag,
    input logic         tmr_out
);
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && cnt_en && en_next && !trig && count != '0) |=> count == $past(count) - W'(1)); // R1
    AST_UF_RELOAD: assert property (@(posedge clk) disable iff (rst)
        uflow |=> count == $past(period)); // R2
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (uflow && oneshot) |=> !running); // R3
    AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (rst)
        trig |=> (running && count == $past(period))); // R13
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (uflow && !oneshot) |=> tmr_out != $past(tmr_out)); // R6
    AST_UF_FLAG: assert property (@(posedge clk) disable iff (rst)
        uflow |=> uf_flag); // R7
    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !en_next |=> !running); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running && !trig) |=> $stable(count)); // R10
endmodule

bind reload_timer rt_checker #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .count(count_w), .period(period_w),
    .running(running_w), .uflow(uflow_w), .trig(trig_w),
    .en_next(en_next_w), .cnt_en(cnt_en), .oneshot(ctrl_w.oneshot),
    .uf_flag(stat_w.uf), .tmr_out(tmr_out)
);

// File: tb/reload_timer_tb.sv
module reload_timer_tb_top;
    localparam int CLK_P = 10;
    localparam int W     = 16;
    localparam logic [1:0] A_CTRL = 2'd0, A_PERIOD = 2'd1, A_STATUS = 2'd2, A_COUNT = 2'd3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         cnt_en = 1'b0;
    logic         trig_in = 1'b0;
    logic         tmr_out, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    reload_timer #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_en(cnt_en), .trig_in(trig_in),
        .tmr_out(tmr_out), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; addr = a; wdata = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic strobe(input int n);
        repeat (n) begin
            cnt_en = 1'b1;
            @(negedge clk);
            cnt_en = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(A_CTRL, v);   chk("R10 reset ctrl", v, 0);
        rd(A_STATUS, v); chk("R7 reset status", v, 0);
        rd(A_COUNT, v);  chk("R1 reset count", v, 0);
        chk("R6 reset out", int'(tmr_out), 0);
        chk("R7 reset irq", int'(irq), 0);

        // sweep: mode x polarity x period
        for (int os = 0; os < 2; os++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int p = 0; p < 7; p++) begin
                    wr(A_CTRL, 0);
                    wr(A_STATUS, 0);
                    wr(A_PERIOD, p);
                    wr(A_CTRL, 3 | (os << 2) | (inv << 3));
                    rd(A_COUNT, v);  chk("R9 sw trigger load", v, p);
                    rd(A_CTRL, v);   chk("R9 sw bit reads 0", (v >> 1) & 1, 0);
                    chk("R6 out after start", int'(tmr_out), inv ^ os);
                    for (int lap = 1; lap <= 2; lap++) begin
                        wr(A_STATUS, 0);
                        for (int k = 1; k <= p; k++) begin
                            strobe(1);
                            rd(A_COUNT, v);
                            if (os == 1 && lap == 2) chk("R3 held after one-shot", v, p);
                            else                     chk("R1 decrement", v, p - k);
                        end
                        strobe(1);
                        rd(A_COUNT, v);
                        chk("R2 reload value", v, p);
                        rd(A_STATUS, v);
                        chk("R7 underflow flag", v & 1, (os == 1 && lap == 2) ? 0 : 1);
                        if (os == 0) chk("R6 toggle level", int'(tmr_out), inv ^ (lap & 1));
                        else         chk("R3 one-shot idle level", int'(tmr_out), inv);
                    end
                end
            end
        end

        // interrupts
        wr(A_CTRL, 0);
        wr(A_STATUS, 16'h10);
        wr(A_PERIOD, 0);
        wr(A_CTRL, 3);
        rd(A_STATUS, v); chk("R8 trigger flag", (v >> 1) & 1, 1);
        chk("R8 irq masked", int'(irq), 0);
        strobe(1);
        chk("R7 irq on underflow", int'(irq), 1);
        wr(A_STATUS, 16'h10);
        chk("R12 clear drops irq", int'(irq), 0);
        rd(A_STATUS, v); chk("R12 flags cleared", v & 3, 0);
        wr(A_STATUS, 16'h13);
        rd(A_STATUS, v); chk("R12 write 1 no set", v & 3, 0);
        wr(A_STATUS, 16'h20);
        wr(A_CTRL, 3);
        chk("R8 irq on trigger", int'(irq), 1);

        // set wins over clear
        wr(A_STATUS, 0);
        cnt_en = 1'b1; wr_en = 1'b1; addr = A_STATUS; wdata = '0;
        @(negedge clk);
        cnt_en = 1'b0; wr_en = 1'b0;
        rd(A_STATUS, v); chk("R12 set wins", v & 1, 1);

        // config lock while enabled
        wr(A_CTRL, 0);
        wr(A_CTRL, 3);
        wr(A_CTRL, 16'h3D);
        rd(A_CTRL, v); chk("R11 locked while enabled", v, 1);
        wr(A_CTRL, 0);
        wr(A_CTRL, 16'h3C);
        rd(A_CTRL, v); chk("R11 accepted when disabled", v, 16'h3C);

        // disable holds count
        wr(A_CTRL, 0);
        wr(A_PERIOD, 5);
        wr(A_CTRL, 3);
        strobe(2);
        rd(A_COUNT, v); chk("R1 mid count", v, 3);
        wr(A_CTRL, 0);
        strobe(3);
        rd(A_COUNT, v); chk("R10 count held", v, 3);
        chk("R10 idle out", int'(tmr_out), 0);
        wr(A_STATUS, 0);
        wr(A_CTRL, 2);
        rd(A_STATUS, v); chk("R9 no trigger without enable", (v >> 1) & 1, 0);
        rd(A_COUNT, v);  chk("R9 count unchanged", v, 3);

        // external edge sweep
        for (int sel = 0; sel < 4; sel++) begin
            bit r_ok, f_ok;
            r_ok = (sel == 1) || (sel == 3);
            f_ok = (sel == 2) || (sel == 3);
            wr(A_CTRL, 0);
            wr(A_STATUS, 0);
            wr(A_PERIOD, 3);
            wr(A_CTRL, (sel << 4) | 1);
            trig_in = 1'b1;
            repeat (2) @(negedge clk);
            rd(A_STATUS, v); chk("R5 not before third edge", (v >> 1) & 1, 0);
            @(negedge clk);
            rd(A_STATUS, v); chk("R4 rising edge decode", (v >> 1) & 1, int'(r_ok));
            if (r_ok) begin
                rd(A_COUNT, v); chk("R5 load on trigger", v, 3);
                strobe(1);
                rd(A_COUNT, v); chk("R1 count after ext start", v, 2);
            end
            wr(A_STATUS, 0);
            trig_in = 1'b0;
            repeat (3) @(negedge clk);
            rd(A_STATUS, v); chk("R4 falling edge decode", (v >> 1) & 1, int'(f_ok));
            if (f_ok) begin
                rd(A_COUNT, v); chk("R13 retrigger reload", v, 3);
            end
        end

        // software retrigger while running
        wr(A_CTRL, 0);
        wr(A_PERIOD, 6);
        wr(A_CTRL, 3);
        strobe(4);
        rd(A_COUNT, v); chk("R1 before retrigger", v, 2);
        wr(A_CTRL, 3);
        rd(A_COUNT, v); chk("R13 sw retrigger", v, 6);

        finish_run();
    end
endmodule